// File: doc/BRIEF.md
# Parity-Sorted Buffer Dump Controller

After reset the block counts through the integers 0 to N_VALUES-1, one value per clock. Each value is written into one of two internal byte buffers chosen by its least significant bit: odd values go to one buffer and even values to the other. Each buffer holds N_VALUES/2 entries, filled at consecutive addresses starting from 0. Two request pulses come from key debouncers outside this block. Each pulse starts a dump of one buffer to a byte-wide serial transmitter, also outside the block. The dump uses a start/done handshake on a single shared start line and data bus.

Each buffer has its own four-state machine: write, idle, a one-cycle preparation state, then read. A machine in preparation or read owns the transmitter outputs, and the odd side has priority. When neither side is dumping, the outputs hold their last value. The buffers keep their contents, so a buffer can be dumped any number of times.

Top module: `parity_dump_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tx_start` is 0 and `tx_byte` is 0.
- R2: After the fill, an `dump_odd_req` pulse produces exactly N_VALUES/2 start pulses. The bytes presented with them are 1, 3, 5, … in ascending order, and each byte is valid on the cycle its start pulse is high.
- R3: After the fill, a `dump_even_req` pulse produces exactly N_VALUES/2 start pulses. The bytes presented with them are 0, 2, 4, … in ascending order.
- R4: After the done that answers the last byte of a dump, no further start is issued. `tx_byte` keeps the last byte sent (99 for odd, 98 for even with defaults) until the next dump begins.
- R5: `tx_start` is a one-cycle pulse. Apart from the first byte of a dump, a start is issued only on the cycle after `tx_done`. No start is issued while the transmitter is still busy with the previous byte.
- R6: Request pulses that arrive during the N_VALUES-cycle fill after reset are ignored, and no start is issued during the fill.
- R7: A request pulse on either input that arrives while a dump is in progress is ignored. The current dump completes with its full, unaltered sequence, and no second dump follows.
- R8: When both request pulses arrive in the same cycle with no dump in progress, only the odd buffer is dumped.
- R9: Buffer contents are retained, so repeated dumps in any order give the same sequences as the first ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dump_odd_req | input | 1 | One-cycle debounced pulse requesting a dump of the odd buffer |
| dump_even_req | input | 1 | One-cycle debounced pulse requesting a dump of the even buffer |
| tx_done | input | 1 | One-cycle pulse from the transmitter when the current byte has been sent |
| tx_start | output | 1 | One-cycle pulse telling the transmitter to send `tx_byte` |
| tx_byte | output | DW | Byte offered to the transmitter, valid while `tx_start` is high |

## Verification
The bench answers every start with a done after a random delay. This catches an address that advances on the wrong edge, which would skip or repeat a value, and data that lags the start by one cycle, which would shift every sampled byte by one position. Request pulses are injected during the fill, in the middle of a dump, and on both keys in the same cycle. A design without the busy lock-out would interleave or restart a dump, and one with the wrong priority would emit even values. The bench also checks that nothing follows the final done and that the last byte stays on the bus, which catches an off-by-one end condition that sends a 51st byte or stops at 49.

// File: rtl/parity_dump_ctrl.sv
module parity_dump_ctrl #(
  parameter int N_VALUES = 100,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dump_odd_req,
  input  logic          dump_even_req,
  input  logic          tx_done,
  output logic          tx_start,
  output logic [DW-1:0] tx_byte
);

  localparam int DEPTH = N_VALUES / 2;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = (N_VALUES > 1) ? $clog2(N_VALUES) : 1;
  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);
  localparam logic [CW-1:0] LAST_V = CW'(N_VALUES - 1);

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_PREP, S_READ} st_t;

  logic [CW-1:0] gen;
  logic          filling;
  logic          fill_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gen     <= '0;
      filling <= 1'b1;
    end else if (filling) begin
      if (gen == LAST_V) filling <= 1'b0;
      else               gen     <= gen + CW'(1);
    end

  assign fill_last = filling && (gen == LAST_V);

  logic [1:0]    busy, prep, idle, go, snx;
  logic [DW-1:0] dnx [2];
  logic          any_busy;

  assign any_busy = |busy;
  assign go[1] = dump_odd_req & idle[1] & ~any_busy;
  assign go[0] = dump_even_req & ~dump_odd_req & idle[0] & ~any_busy;

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam logic PAR = (s == 1);
    st_t           st;
    logic [AW-1:0] addr;
    logic [DW-1:0] mem [DEPTH];
    logic          wr, at_end;

    assign wr     = filling && (gen[0] == PAR);
    assign at_end = (addr == LAST_A);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        st   <= S_WRITE;
        addr <= '0;
      end else begin
        case (st)
          S_WRITE: begin
            if (wr && !at_end) addr <= addr + AW'(1);
            if (fill_last)     st   <= S_IDLE;
          end
          S_IDLE:  if (go[s]) st <= S_PREP;
          S_PREP: begin
            addr <= '0;
            st   <= S_READ;
          end
          S_READ:
            if (tx_done) begin
              if (at_end) st   <= S_IDLE;
              else        addr <= addr + AW'(1);
            end
          default: st <= S_IDLE;
        endcase
      end

    always_ff @(posedge clk)
      if (wr) mem[addr] <= DW'(gen);

    assign busy[s] = (st == S_PREP) || (st == S_READ);
    assign prep[s] = (st == S_PREP);
    assign idle[s] = (st == S_IDLE);
    assign snx[s]  = (st == S_PREP) || ((st == S_READ) && tx_done && !at_end);
    assign dnx[s]  = (st == S_PREP) ? mem[0] :
                     ((st == S_READ) && tx_done && !at_end) ? mem[addr + AW'(1)] :
                     mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_start <= 1'b0;
      tx_byte  <= '0;
    end else if (busy[1]) begin
      tx_start <= snx[1];
      tx_byte  <= dnx[1];
    end else if (busy[0]) begin
      tx_start <= snx[0];
      tx_byte  <= dnx[0];
    end

  AST_SINGLE_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy[0] && busy[1])); // R7

  AST_START_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> ($past(tx_done) || $past(|prep))); // R5

  AST_QUIET_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    filling |-> !tx_start); // R6

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !any_busy |=> $stable(tx_byte)); // R4

  AST_SIDE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_byte[0] == $past(busy[1]))); // R2

endmodule

// File: tb/sim_parity_dump_ctrl.sv
module sim_parity_dump_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV   = 100;
  localparam int HALF = NV / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kodd = 1'b0, keven = 1'b0, tx_done = 1'b0;
  logic       tx_start;
  logic [7:0] tx_byte;

  int tests = 0, fails = 0;
  int cd = 0, viol = 0, maxd = 4, cyc = 0;
  int cap[$];

  parity_dump_ctrl #(.N_VALUES(NV), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .dump_odd_req(kodd), .dump_even_req(keven),
    .tx_done(tx_done), .tx_start(tx_start), .tx_byte(tx_byte));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (cd > 0) begin
      cd--;
      tx_done = (cd == 0);
    end else tx_done = 1'b0;
    if (tx_start) begin
      if (cd > 0) viol++;
      cap.push_back(int'(tx_byte));
      cd = 1 + int'($urandom % maxd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int exp_val(bit odd, int i);
    return odd ? 2*i + 1 : 2*i;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(bit o, bit e);
    @(negedge clk);
    kodd = o; keven = e;
    @(negedge clk);
    kodd = 1'b0; keven = 1'b0;
  endtask

  task automatic wait_quiet();
    int n = 0;
    while (cap.size() < HALF && n < 2000) begin @(negedge clk); n++; end
    repeat (3 * maxd + 10) @(negedge clk);
  endtask

  task automatic check_seq(bit odd, string req);
    int bad = 0;
    check(cap.size() == HALF, req, cap.size(), HALF);
    foreach (cap[i]) if (i < HALF && cap[i] != exp_val(odd, i) && bad == 0) begin
      bad = 1;
      check(0, req, cap[i], exp_val(odd, i));
    end
    if (bad == 0) check(1, req, 0, 0);
  endtask

  task automatic hold_check(bit odd);
    int ok = 1;
    repeat (20) begin
      @(negedge clk);
      if (tx_start || tx_byte != 8'(exp_val(odd, HALF - 1))) ok = 0;
    end
    check(ok == 1 && cap.size() == HALF, "R4", int'(tx_byte), exp_val(odd, HALF - 1));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(tx_start == 1'b0, "R1", int'(tx_start), 0);
    check(tx_byte == 8'd0, "R1", int'(tx_byte), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_start == 1'b0 && tx_byte == 8'd0, "R1", int'(tx_byte), 0);

    // R6: requests during the fill
    pulse(1, 0);
    repeat (10) @(negedge clk);
    pulse(0, 1);
    repeat (20) @(negedge clk);
    pulse(1, 1);
    repeat (NV + 20) @(negedge clk);
    check(cap.size() == 0, "R6", cap.size(), 0);

    // R2 odd dump
    cap.delete();
    pulse(1, 0);
    wait_quiet();
    check_seq(1, "R2");
    hold_check(1);

    // R3 even dump, R7 requests mid-dump
    cap.delete();
    pulse(0, 1);
    repeat (30) @(negedge clk);
    pulse(1, 0);
    repeat (40) @(negedge clk);
    pulse(0, 1);
    repeat (15) @(negedge clk);
    pulse(1, 1);
    wait_quiet();
    check_seq(0, "R3");
    check_seq(0, "R7");
    hold_check(0);

    // R8 both keys at once
    cap.delete();
    pulse(1, 1);
    wait_quiet();
    check_seq(1, "R8");

    // R9 random repeats with varying transmitter delay
    for (int k = 0; k < 6; k++) begin
      bit o;
      o = 1'($urandom % 2);
      maxd = 1 + int'($urandom % 9);
      cap.delete();
      pulse(o, ~o);
      repeat (int'($urandom % 60)) @(negedge clk);
      pulse(1'($urandom % 2), 1'($urandom % 2));
      wait_quiet();
      check_seq(o, "R9");
    end

    check(viol == 0, "R5", viol, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule